// File: doc/BRIEF.md
# Atomic Swap Memory Responder

A byte-addressed memory target that answers one request at a time. A request names an operation, an access size of 1, 2, 4 or 8 bytes, a byte address, write data and a compare value. The four operations are a plain read, a plain write, an invalidate (acknowledged with no memory effect) and an atomic read-modify-write. The atomic operation always returns the old contents of the addressed bytes. Without the conditional flag it then stores the new value, which makes it a swap. With the flag it stores only when the old contents equal the compare value, which makes it a compare-and-swap.

Storage is a set of 64-bit words mapped at a parameterised, 8-byte-aligned base address. Data is little-endian: the low address bits select the byte lanes, and read results come back right-aligned and zero-extended. Each accepted request produces one response, marked valid for a single cycle, a fixed number of cycles later. The responder takes no new request while one is pending. Requests that fall outside the window, are not aligned to their size, or use a compare-and-swap narrower than 4 bytes get an error response and leave memory alone. A parameter can clear all storage on reset.

Top module: `atomic_mem_resp`

## Requirements
- R1: A read (op code 0) returns the addressed bytes right-aligned and zero-extended, little-endian. Size code 0/1/2/3 means 1/2/4/8 bytes.
- R2: A write (op code 1) changes only the byte lanes it covers. Write-data bits above the access size are ignored, and the response data is zero.
- R3: An atomic operation (op code 3) with `req_cond` low returns the old bytes and always stores the new value.
- R4: An atomic operation with `req_cond` high returns the old bytes. It stores the new value only when the old bytes equal the low access-size bytes of `req_cmp`; higher compare bits are ignored.
- R5: A conditional atomic operation with size code 0 or 1 gets an error response, zero data and no memory change.
- R6: An access that is not fully inside the window [BASE, BASE + 8*WORDS), or whose address is not a multiple of its size, gets an error response, zero data and no memory change.
- R7: An invalidate (op code 2) gets a success response with zero data and leaves memory unchanged.
- R8: A write accepted with `wr_inhibit` high gets a success response but leaves memory unchanged.
- R9: `rsp_valid` is high for exactly one cycle, LATENCY cycles after the clock edge that accepted the request. It carries that request's `rsp_err` and `rsp_data`.
- R10: `req_ready` is low from the accepting edge until after the response cycle, so at most one request is pending.
- R11: With ZERO_INIT set, every memory word reads as zero after reset.
- R12: While in reset and right after it, `rsp_valid` is low and `req_ready` is high. A request pending at reset never gets a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Responder can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 invalidate, 3 atomic |
| req_cond | input | 1 | Atomic operation is conditional (compare-and-swap) |
| req_size | input | 2 | Access size code, 2^code bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write / swap value, right-aligned |
| req_cmp | input | 64 | Compare value, right-aligned |
| wr_inhibit | input | 1 | Suppresses the memory update of a plain write |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_err | output | 1 | Request was illegal |
| rsp_data | output | 64 | Read or old data, right-aligned |

## Verification
The bench compares compare-and-swap against a value whose upper compare bits are garbage. A design that compared all 64 bits would refuse the write and leave the word unchanged. It follows rejected requests with reads: a misaligned write, an access below and just above the window, and a 1- or 2-byte conditional swap. A design that only raised the error flag would still corrupt the word, and the read-back catches it. Narrow swaps at odd byte offsets and writes with junk in the upper data bits expose lane-shift and masking mistakes. The bench also counts cycles to every response and resets the block while a request is pending, to catch an off-by-one latency or a stale response leaking out after reset.

// File: rtl/atomic_mem_pkg.sv
`timescale 1ns/1ps
package atomic_mem_pkg;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_INVAL  = 2'd2,
    OP_ATOMIC = 2'd3
  } op_e;
endpackage

// File: rtl/amr_rst_sync.sv
`timescale 1ns/1ps
module amr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/amr_exec.sv
`timescale 1ns/1ps
module amr_exec
  import atomic_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 64,
  parameter int WORDS  = 16,
  parameter int IDX_W  = 4
) (
  input  logic                active,
  input  logic [1:0]          op,
  input  logic                cond,
  input  logic [1:0]          size,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   cmp,
  input  logic                inhibit,
  input  logic [DATA_W-1:0]   rword,
  output logic [IDX_W-1:0]    idx,
  output logic                we,
  output logic [LANES-1:0]    bmask,
  output logic [DATA_W-1:0]   wword,
  output logic                err,
  output logic [DATA_W-1:0]   rdata
);
  localparam logic [ADDR_W:0]   SPAN_V = (ADDR_W+1)'(WORDS * LANES);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  op_e               op_t;
  logic [ADDR_W-1:0] rel;
  logic              in_rng, aligned, size_ok, do_wr, cmp_hit;
  logic [2:0]        off, amask;
  logic [5:0]        sh;
  logic [DATA_W-1:0] szmask, old;
  logic [LANES-1:0]  lanes;

  always_comb begin
    op_t = op_e'(op);
    case (size)
      2'd0:    begin szmask = 64'h0000_0000_0000_00FF; lanes = 8'h01; amask = 3'd0; end
      2'd1:    begin szmask = 64'h0000_0000_0000_FFFF; lanes = 8'h03; amask = 3'd1; end
      2'd2:    begin szmask = 64'h0000_0000_FFFF_FFFF; lanes = 8'h0F; amask = 3'd3; end
      default: begin szmask = {DATA_W{1'b1}};          lanes = 8'hFF; amask = 3'd7; end
    endcase
    rel     = addr - BASE_V;
    in_rng  = (addr >= BASE_V) && ({1'b0, rel} < SPAN_V);
    aligned = (addr[2:0] & amask) == 3'd0;
    size_ok = !(op_t == OP_ATOMIC && cond && !size[1]);
    err     = !(in_rng && aligned && size_ok);
    off     = addr[2:0];
    sh      = {off, 3'b000};
    old     = (rword >> sh) & szmask;
    cmp_hit = old == (cmp & szmask);
    wword   = (wdata & szmask) << sh;
    bmask   = lanes << off;
    idx     = rel[IDX_W+2:3];
    case (op_t)
      OP_WRITE:  do_wr = !inhibit;
      OP_ATOMIC: do_wr = !cond || cmp_hit;
      default:   do_wr = 1'b0;
    endcase
    we    = active && !err && do_wr;
    rdata = (err || op_t == OP_WRITE || op_t == OP_INVAL) ? '0 : old;
  end
endmodule

// File: rtl/amr_store.sv
`timescale 1ns/1ps
module amr_store
  import atomic_mem_pkg::*;
#(
  parameter int WORDS     = 16,
  parameter int IDX_W     = 4,
  parameter bit ZERO_INIT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   idx,
  input  logic               we,
  input  logic [LANES-1:0]   bmask,
  input  logic [DATA_W-1:0]  wword,
  output logic [DATA_W-1:0]  rword
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] merged;
  logic              idx_ok;

  always_comb begin
    idx_ok = {1'b0, idx} < (IDX_W+1)'(WORDS);
    rword  = idx_ok ? mem_q[idx] : '0;
    merged = rword;
    for (int b = 0; b < LANES; b++)
      if (bmask[b]) merged[b*8 +: 8] = wword[b*8 +: 8];
  end

  generate
    if (ZERO_INIT) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else if (we && idx_ok) begin
          mem_q[idx] <= merged;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (we && idx_ok) mem_q[idx] <= merged;
      end
    end
  endgenerate
endmodule

// File: rtl/amr_timer.sv
`timescale 1ns/1ps
module amr_timer
  import atomic_mem_pkg::*;
#(
  parameter int LATENCY = 3,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              err_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              idle,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (accept)            cnt_nx = CNT_W'(LATENCY);
    else if (cnt_q != '0)  cnt_nx = cnt_q - 1'b1;
    else                   cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_err  <= 1'b0;
      rsp_data <= '0;
    end else if (accept) begin
      rsp_err  <= err_in;
      rsp_data <= data_in;
    end
  end

  assign idle      = cnt_q == '0;
  assign rsp_valid = cnt_q == CNT_W'(1);
endmodule

// File: rtl/atomic_mem_resp.sv
`timescale 1ns/1ps
module atomic_mem_resp
  import atomic_mem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE      = 64,
  parameter int WORDS     = 16,
  parameter int LATENCY   = 3,
  parameter bit ZERO_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_cond,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [63:0]       req_cmp,
  input  logic              wr_inhibit,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_data
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic              rst_sync_n, accept, mem_we, ex_err;
  logic [IDX_W-1:0]  mem_idx;
  logic [LANES-1:0]  mem_bmask;
  logic [DATA_W-1:0] mem_wword, mem_rword, ex_rdata;

  assign accept = req_valid && req_ready;

  amr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  amr_exec #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS), .IDX_W(IDX_W)) u_exec (
    .active(accept), .op(req_op), .cond(req_cond), .size(req_size),
    .addr(req_addr), .wdata(req_wdata), .cmp(req_cmp), .inhibit(wr_inhibit),
    .rword(mem_rword), .idx(mem_idx), .we(mem_we), .bmask(mem_bmask),
    .wword(mem_wword), .err(ex_err), .rdata(ex_rdata)
  );

  amr_store #(.WORDS(WORDS), .IDX_W(IDX_W), .ZERO_INIT(ZERO_INIT)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .idx(mem_idx), .we(mem_we),
    .bmask(mem_bmask), .wword(mem_wword), .rword(mem_rword)
  );

  amr_timer #(.LATENCY(LATENCY), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .accept(accept), .err_in(ex_err),
    .data_in(ex_rdata), .idle(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/atomic_mem_resp_chk.sv
`timescale 1ns/1ps
module atomic_mem_resp_chk #(
  parameter int LATENCY = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_op,
  input logic        req_cond,
  input logic [1:0]  req_size,
  input logic        wr_inhibit,
  input logic        mem_we,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_data
);
  logic        acc;
  logic [15:0] age_q;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (acc)            age_q <= 16'd1;
    else if (rsp_valid)      age_q <= '0;
    else if (age_q != '0)    age_q <= age_q + 16'd1;
  end

  assert_rsp_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> age_q == 16'(LATENCY));
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);
  assert_busy_at_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_narrow_cas_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd3 && req_cond && !req_size[1]) |-> !mem_we);
  assert_err_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_data == 64'd0);
  assert_inval_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd2) |-> !mem_we);
  assert_inhibit_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd1 && wr_inhibit) |-> !mem_we);
endmodule

bind atomic_mem_resp atomic_mem_resp_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_cond(req_cond), .req_size(req_size),
  .wr_inhibit(wr_inhibit), .mem_we(mem_we), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_data(rsp_data)
);

// File: tb/atomic_mem_resp_tb_top.sv
`timescale 1ns/1ps
module atomic_mem_resp_tb_top;
  localparam int LAT = 3;

  logic        clk, rst_n, req_valid, req_cond, wr_inhibit;
  logic [1:0]  req_op, req_size;
  logic [7:0]  req_addr;
  logic [63:0] req_wdata, req_cmp, rsp_data;
  logic        req_ready, rsp_valid, rsp_err;

  int n_run = 0;
  int n_fail = 0;

  atomic_mem_resp #(.ADDR_W(8), .BASE(64), .WORDS(16), .LATENCY(LAT), .ZERO_INIT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_cond(req_cond), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cmp(req_cmp), .wr_inhibit(wr_inhibit),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  op;
    logic        cond;
    logic [1:0]  size;
    logic [7:0]  addr;
    logic [63:0] wdata;
    logic [63:0] cmp;
    logic        inh;
    logic        err;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{8'd11, 2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0},                  // R11 zeroed
    '{8'd2,  2'd1, 1'b0, 2'd3, 8'h40, 64'h1122334455667788, 64'h0, 1'b0, 1'b0, 64'h0},  // R2
    '{8'd1,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'h1122334455667788},  // R1
    '{8'd1,  2'd0, 1'b0, 2'd1, 8'h42, 64'h0, 64'h0, 1'b0, 1'b0, 64'h5566},              // R1 lanes
    '{8'd2,  2'd1, 1'b0, 2'd0, 8'h47, 64'hFFFFFFFFFFFFFFAB, 64'h0, 1'b0, 1'b0, 64'h0},  // R2 junk upper
    '{8'd2,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hAB22334455667788},
    '{8'd3,  2'd3, 1'b0, 2'd2, 8'h44, 64'hDEADBEEF, 64'h0, 1'b0, 1'b0, 64'hAB223344},   // R3 swap
    '{8'd3,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hDEADBEEF55667788},
    '{8'd4,  2'd3, 1'b1, 2'd2, 8'h40, 64'h0, 64'h12345678, 1'b0, 1'b0, 64'h55667788},   // R4 miss
    '{8'd4,  2'd0, 1'b0, 2'd2, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'h55667788},
    '{8'd4,  2'd3, 1'b1, 2'd2, 8'h40, 64'hCAFEF00D, 64'hAAAAAAAA55667788, 1'b0, 1'b0, 64'h55667788}, // R4 hit
    '{8'd4,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hDEADBEEFCAFEF00D},
    '{8'd5,  2'd3, 1'b1, 2'd1, 8'h40, 64'h1111, 64'hF00D, 1'b0, 1'b1, 64'h0},           // R5
    '{8'd5,  2'd3, 1'b1, 2'd0, 8'h40, 64'h22, 64'h0D, 1'b0, 1'b1, 64'h0},               // R5
    '{8'd5,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hDEADBEEFCAFEF00D},
    '{8'd3,  2'd3, 1'b0, 2'd0, 8'h41, 64'h99, 64'h0, 1'b0, 1'b0, 64'hF0},               // R3 byte
    '{8'd3,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hDEADBEEFCAFE990D},
    '{8'd6,  2'd1, 1'b0, 2'd2, 8'h42, 64'h0, 64'h0, 1'b0, 1'b1, 64'h0},                 // R6 misaligned
    '{8'd6,  2'd1, 1'b0, 2'd3, 8'h38, 64'h0, 64'h0, 1'b0, 1'b1, 64'h0},                 // R6 below
    '{8'd6,  2'd0, 1'b0, 2'd3, 8'hC0, 64'h0, 64'h0, 1'b0, 1'b1, 64'h0},                 // R6 above
    '{8'd6,  2'd1, 1'b0, 2'd3, 8'hB8, 64'h0102030405060708, 64'h0, 1'b0, 1'b0, 64'h0},  // R6 last word
    '{8'd6,  2'd0, 1'b0, 2'd3, 8'hB8, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0102030405060708},
    '{8'd6,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hDEADBEEFCAFE990D},
    '{8'd7,  2'd2, 1'b0, 2'd3, 8'h40, 64'hFFFFFFFFFFFFFFFF, 64'h0, 1'b0, 1'b0, 64'h0},  // R7
    '{8'd7,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hDEADBEEFCAFE990D},
    '{8'd8,  2'd1, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b1, 1'b0, 64'h0},                 // R8
    '{8'd8,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'hDEADBEEFCAFE990D},
    '{8'd4,  2'd3, 1'b1, 2'd3, 8'hB8, 64'hFFFF, 64'h0102030405060708, 1'b0, 1'b0, 64'h0102030405060708},
    '{8'd4,  2'd0, 1'b0, 2'd3, 8'hB8, 64'h0, 64'h0, 1'b0, 1'b0, 64'hFFFF},
    '{8'd3,  2'd3, 1'b0, 2'd1, 8'h46, 64'h1234, 64'h0, 1'b0, 1'b0, 64'hDEAD},
    '{8'd3,  2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'h1234BEEFCAFE990D}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input int n);
    int k;
    string tag;
    tag = $sformatf("R%0d vec%0d", v.rq, n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_cond = v.cond; req_size = v.size;
    req_addr = v.addr; req_wdata = v.wdata; req_cmp = v.cmp; wr_inhibit = v.inh;
    @(negedge clk);
    req_valid = 1'b0; wr_inhibit = 1'b0;
    k = 1;
    chk(!req_ready, "R10 busy", 64'(req_ready), 64'd0);
    while (!rsp_valid && k < LAT + 5) begin
      @(negedge clk);
      k++;
    end
    chk(k == LAT, {tag, " R9 latency"}, 64'(k), 64'(LAT));
    chk(rsp_err == v.err, {tag, " err"}, 64'(rsp_err), 64'(v.err));
    chk(rsp_data == v.exp, {tag, " data"}, rsp_data, v.exp);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 pulse / R10 ready", 64'({rsp_valid, req_ready}), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_cond = 1'b0; req_size = 2'd0;
    req_addr = 8'h0; req_wdata = 64'h0; req_cmp = 64'h0; wr_inhibit = 1'b0;
    @(negedge clk);
    // R12: outputs while held in reset
    chk(!rsp_valid && req_ready, "R12 in reset", 64'({rsp_valid, req_ready}), 64'd1);
    do_reset();
    chk(!rsp_valid && req_ready, "R12 after reset", 64'({rsp_valid, req_ready}), 64'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R12: reset while a request is pending drops its response
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_size = 2'd3; req_addr = 8'h40; req_cond = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      for (int c = 0; c < LAT + 4; c++) begin
        @(negedge clk);
        if (rsp_valid) seen = 1'b1;
      end
      chk(!seen, "R12 pending dropped", 64'(seen), 64'd0);
    end
    chk(req_ready, "R12 ready after mid reset", 64'(req_ready), 64'd1);

    // R11: storage cleared again by that reset
    run_vec('{8'd11, 2'd0, 1'b0, 2'd3, 8'hB8, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0}, 100);
    run_vec('{8'd11, 2'd0, 1'b0, 2'd3, 8'h40, 64'h0, 64'h0, 1'b0, 1'b0, 64'h0}, 101);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule